// File: doc/BRIEF.md
# Display Memory Blink Selector

This block decides which of two segment memory banks feeds a segment display driver: the normal image bank or the alternate blink bank. It has two ways of choosing. In manual mode a select bit names the bank outright. In automatic mode a half-period tick from an external blink divider alternates the banks, so that the display flashes between the two images.

Every change of the active bank waits for a frame-boundary strobe, so a single frame never mixes data from the two banks. The block takes the read-data words of both banks and passes one of them through unchanged. It also reports which bank is active. Disabling the display returns the block to the normal bank and clears its alternation state.

Top module: `disp_bank_sel`

## Requirements
- R1: After the asynchronous reset `rst_ni` is asserted, `bank_o` is 0 (normal bank) and `data_o` equals `norm_data_i`.
- R2: In the same cycle, `data_o` equals `norm_data_i` while `bank_o` is 0 and equals `blink_data_i` while `bank_o` is 1.
- R3: When `mode_i` is 00, 01 or 10, the block is in manual mode. A clock edge with `frame_i` and `disp_en_i` high loads `sel_i` into `bank_o` (0 is the normal bank, 1 is the blink bank).
- R4: `bank_o` changes only on an edge where `frame_i` is high. Changes of `sel_i`, `mode_i` or `blink_tick_i` on other cycles leave `bank_o` unchanged until the next frame strobe.
- R5: When `mode_i` becomes 11 (auto mode), the blink phase restarts at the normal half. The first frame strobe after entry selects the normal bank whatever `sel_i` is, including a strobe in the entry cycle itself.
- R6: In auto mode each `blink_tick_i` pulse flips the blink phase. The next frame strobe applies the new phase: the normal bank in the first half and the blink bank in the second half.
- R7: A tick and a frame strobe in the same cycle in auto mode apply the flipped phase at that frame boundary.
- R8: When `mode_i` leaves 11, the manual `sel_i` takes effect at the next frame strobe. Ticks have no effect outside auto mode.
- R9: While `disp_en_i` is low, `bank_o` is 0 from the next edge on and frame strobes are ignored. Enabling the display again while in auto mode restarts the phase at the normal half.
- R10: Two ticks between frame strobes cancel out. The bank applied at a frame follows the current phase, not the number of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_en_i | input | 1 | Display enable; low clears the state to the normal bank |
| frame_i | input | 1 | Frame-boundary strobe, one cycle |
| blink_tick_i | input | 1 | Blink divider half-period tick, one cycle |
| mode_i | input | 2 | Blink mode; 11 selects automatic alternation |
| sel_i | input | 1 | Manual bank select: 0 normal, 1 blink |
| norm_data_i | input | DATA_W | Read data of the normal image bank |
| blink_data_i | input | DATA_W | Read data of the blink bank |
| data_o | output | DATA_W | Data of the active bank |
| bank_o | output | 1 | Active bank: 0 normal, 1 blink |

## Verification
The bench changes the select, the mode and the tick between frame strobes. A design that switched banks at once, instead of at the boundary, would show a bank change with no strobe present. It enters auto mode with the select already at 1, both with and without a strobe in the entry cycle. A design that kept a stale phase or copied the select would start on the blink bank. It also drives a tick and a strobe in the same cycle, and two ticks before one strobe. Dropping the coincident tick, or counting ticks instead of tracking phase, would leave the wrong bank on screen. Last, it disables and re-enables the display while in auto mode and pulses the reset in the middle of a run. A design that did not clear its phase on disable would resume on the blink half.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [1:0] {
    BLK_NONE = 2'b00,
    BLK_RSV1 = 2'b01,
    BLK_RSV2 = 2'b10,
    BLK_AUTO = 2'b11
  } blk_mode_e;

  typedef enum logic {
    BANK_NORM  = 1'b0,
    BANK_BLINK = 1'b1
  } bank_e;
endpackage

// File: rtl/dbs_phase_gen.sv
module dbs_phase_gen
  import dbs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic auto_i,
  input  logic tick_i,
  output bank_e phase_next_o
);
  logic  auto_q;
  bank_e phase_q;
  logic  entry;

  assign entry = auto_i && !auto_q;

  // next phase includes a tick in the current cycle
  always_comb begin
    if (!auto_i || entry)  phase_next_o = BANK_NORM;
    else if (tick_i)       phase_next_o = (phase_q == BANK_NORM) ? BANK_BLINK : BANK_NORM;
    else                   phase_next_o = phase_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_q  <= 1'b0;
      phase_q <= BANK_NORM;
    end else if (!en_i) begin
      auto_q  <= 1'b0;
      phase_q <= BANK_NORM;
    end else begin
      auto_q  <= auto_i;
      phase_q <= phase_next_o;
    end
  end
endmodule

// File: rtl/dbs_frame_latch.sv
module dbs_frame_latch
  import dbs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  frame_i,
  input  bank_e target_i,
  output bank_e bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bank_o <= BANK_NORM;
    else if (!en_i)    bank_o <= BANK_NORM;
    else if (frame_i)  bank_o <= target_i;
  end
endmodule

// File: rtl/dbs_data_mux.sv
module dbs_data_mux
  import dbs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  bank_e             bank_i,
  input  logic [DATA_W-1:0] norm_i,
  input  logic [DATA_W-1:0] blink_i,
  output logic [DATA_W-1:0] data_o
);
  assign data_o = (bank_i == BANK_BLINK) ? blink_i : norm_i;
endmodule

// File: rtl/disp_bank_sel.sv
module disp_bank_sel
  import dbs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_en_i,
  input  logic              frame_i,
  input  logic              blink_tick_i,
  input  logic [1:0]        mode_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] norm_data_i,
  input  logic [DATA_W-1:0] blink_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bank_o
);
  logic  auto_mode;
  bank_e phase_next;
  bank_e target;
  bank_e bank_q;

  assign auto_mode = (blk_mode_e'(mode_i) == BLK_AUTO);
  assign target    = auto_mode ? phase_next : bank_e'(sel_i);

  dbs_phase_gen u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (disp_en_i),
    .auto_i       (auto_mode),
    .tick_i       (blink_tick_i),
    .phase_next_o (phase_next)
  );

  dbs_frame_latch u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (disp_en_i),
    .frame_i  (frame_i),
    .target_i (target),
    .bank_o   (bank_q)
  );

  dbs_data_mux #(.DATA_W(DATA_W)) u_mux (
    .bank_i  (bank_q),
    .norm_i  (norm_data_i),
    .blink_i (blink_data_i),
    .data_o  (data_o)
  );

  assign bank_o = (bank_q == BANK_BLINK);
endmodule

// File: rtl/disp_bank_sel_chk.sv
module disp_bank_sel_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       disp_en_i,
  input logic       frame_i,
  input logic [1:0] mode_i,
  input logic       sel_i,
  input logic       bank_o
);
  // R4
  no_midframe_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_en_i && !frame_i) |=> $stable(bank_o));

  // R3
  manual_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_en_i && frame_i && mode_i != 2'b11) |=> (bank_o == $past(sel_i)));

  // R5
  auto_entry_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_en_i && frame_i && mode_i == 2'b11 && $past(mode_i) != 2'b11) |=> !bank_o);

  // R9
  disabled_norm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_en_i |=> !bank_o);
endmodule

bind disp_bank_sel disp_bank_sel_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .disp_en_i (disp_en_i),
  .frame_i   (frame_i),
  .mode_i    (mode_i),
  .sel_i     (sel_i),
  .bank_o    (bank_o)
);

// File: tb/tb_disp_bank_sel.sv
module tb_disp_bank_sel;
  localparam int DATA_W = 16;
  localparam int NV = 26;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              disp_en_i = 1'b0;
  logic              frame_i = 1'b0;
  logic              blink_tick_i = 1'b0;
  logic [1:0]        mode_i = 2'b00;
  logic              sel_i = 1'b0;
  logic [DATA_W-1:0] norm_data_i = '0;
  logic [DATA_W-1:0] blink_data_i = '0;
  logic [DATA_W-1:0] data_o;
  logic              bank_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  disp_bank_sel #(.DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .disp_en_i(disp_en_i), .frame_i(frame_i),
    .blink_tick_i(blink_tick_i), .mode_i(mode_i), .sel_i(sel_i),
    .norm_data_i(norm_data_i), .blink_data_i(blink_data_i),
    .data_o(data_o), .bank_o(bank_o)
  );

  // {req[3:0], en, mode[1:0], sel, tick, frame, exp_bank}
  localparam logic [10:0] VEC [NV] = '{
    {4'd4,  1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 sel without frame
    {4'd3,  1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1}, // R3 manual blink
    {4'd4,  1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R4
    {4'd3,  1'b1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 mode 01 manual
    {4'd3,  1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1}, // R3 mode 10 manual
    {4'd4,  1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1}, // R4 entry, no frame
    {4'd5,  1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 first half normal
    {4'd6,  1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0}, // R6 tick held
    {4'd6,  1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    {4'd6,  1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1}, // R6 applied at frame
    {4'd7,  1'b1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0}, // R7 tick+frame
    {4'd10, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0}, // R10
    {4'd10, 1'b1, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0}, // R10
    {4'd10, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0}, // R10 ticks cancel
    {4'd6,  1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0}, // R6
    {4'd6,  1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1}, // R6 blink half
    {4'd8,  1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 leave, held
    {4'd8,  1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0}, // R8 manual applied
    {4'd8,  1'b1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1}, // R8 tick ignored
    {4'd5,  1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0}, // R5 entry with frame
    {4'd7,  1'b1, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1}, // R7
    {4'd9,  1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0}, // R9 disable
    {4'd9,  1'b0, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0}, // R9 frame ignored
    {4'd9,  1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0}, // R9 re-enable restarts
    {4'd6,  1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0}, // R6
    {4'd6,  1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1}  // R6
  };

  task automatic check_out(input int req, input logic exp_bank);
    logic [DATA_W-1:0] exp_data;
    exp_data = exp_bank ? blink_data_i : norm_data_i;
    checks++;
    if (bank_o !== exp_bank) begin
      fails++;
      $display("FAIL R%0d bank_o actual %0b expected %0b", req, bank_o, exp_bank);
    end
    checks++;
    if (data_o !== exp_data) begin
      fails++;
      // R2 data follows bank
      $display("FAIL R%0d/R2 data_o actual %h expected %h", req, data_o, exp_data);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    norm_data_i  = 16'h5A5A;
    blink_data_i = 16'hC3C3;
    repeat (2) @(negedge clk);
    check_out(1, 1'b0); // R1 reset state
    rst_ni    = 1'b1;
    disp_en_i = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      v = VEC[i];
      disp_en_i    = v[6];
      mode_i       = v[5:4];
      sel_i        = v[3];
      blink_tick_i = v[2];
      frame_i      = v[1];
      norm_data_i  = 16'h1000 + 16'(i);
      blink_data_i = 16'hB000 ^ 16'(i * 7);
      @(posedge clk);
      @(negedge clk);
      check_out(int'(v[10:7]), v[0]);
    end

    // R2: data patterns change while bank held at blink
    frame_i = 1'b0; blink_tick_i = 1'b0;
    blink_data_i = 16'hFFFF; norm_data_i = 16'h0000;
    #1 check_out(2, 1'b1);
    blink_data_i = 16'h0001; norm_data_i = 16'h8000;
    #1 check_out(2, 1'b1);

    // R1: asynchronous reset in mid-run
    #3 rst_ni = 1'b0;
    #1 check_out(1, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    mode_i = 2'd0; sel_i = 1'b1; frame_i = 1'b1;
    @(posedge clk); @(negedge clk);
    check_out(3, 1'b1);
    frame_i = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule